// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Bus Engine

This block is the bus-facing half of a serial memory slave on a two-wire bus. It receives the clock and data lines as samples that are already synchronised to the local clock. It detects bus start and stop conditions, counts bit clocks and shifts bytes in and out. It also decodes the selection byte that follows every start condition. The block drives the data line only through an active-low pull enable, so the output is open drain. It reports received bytes, the page bits and the transfer direction to the memory side, and it asks that side for each byte it must send.

The selection byte holds a fixed 4-bit tag, a bit compared with a board strap, two page bits that act as the high memory-address bits, and the direction bit. The block acknowledges a matching selection byte and every byte written after it. While the memory side reports a write cycle in progress, the block withholds the acknowledge from every selection byte, so a master can poll until the write completes. In a read the master acknowledges each byte to continue and ends the read with a NACK followed by STOP.

Top module: `twi_slave_engine`

## Requirements
- R1: A data falling edge while the clock is high is a START, from any state and also without a STOP before it. It discards any partial byte and makes the next 8 clock rises the selection byte.
- R2: A selection byte is accepted when bits 7:4 equal 1010 and bit 3 equals `strap_i`. The slave then holds `sda_pull_o` high from the clock fall after the 8th rise until the clock fall after the 9th rise.
- R3: A selection byte with a wrong tag or strap bit gets no acknowledge. Until the next START the block gives no pull, no `rx_valid_o` and no `tx_req_o`, even for later bytes that would match.
- R4: While `wr_busy_i` is high at the 8th rise of a selection byte, the byte is not acknowledged and is treated as a mismatch.
- R5: On an accepted selection byte, `page_o` takes bits 2:1 and `rnw_o` takes bit 0 (1 means read). Both hold their value until the next accepted selection byte.
- R6: In a write, every byte received is acknowledged. It appears on `rx_byte_o` with a one-cycle `rx_valid_o` pulse, and `rx_word_o` is 1 only for the first byte after the selection byte.
- R7: In a read, each byte from `tx_byte_i` is sent MSB first, with `sda_pull_o` high for a 0 bit. The first bit is driven after the clock fall that ends the acknowledge clock, and each later bit after the next clock fall.
- R8: `tx_req_o` pulses once when a read selection byte is accepted and once each time the master acknowledges a byte (data low on the 9th rise). After a NACK the bus stays released and no request follows until START.
- R9: A STOP (data rising edge while the clock is high) releases the bus, returns the block to idle and gives a one-cycle `stop_o` pulse. After reset every output is 0.
- R10: `sda_pull_o` changes only in the clock cycle after a clock fall is seen, never while the clock stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Synchronised bus clock sample |
| sda_i | input | 1 | Synchronised bus data sample (wired-AND line) |
| strap_i | input | 1 | Board strap compared with selection bit 3 |
| wr_busy_i | input | 1 | Memory write cycle in progress |
| tx_byte_i | input | 8 | Byte to send, captured when the acknowledge clock ends |
| sda_pull_o | output | 1 | Pull data line low when 1 |
| page_o | output | 2 | Page bits of the last accepted selection byte |
| rnw_o | output | 1 | Direction of the last accepted selection byte |
| rx_valid_o | output | 1 | One-cycle strobe for a received write byte |
| rx_byte_o | output | 8 | Received write byte |
| rx_word_o | output | 1 | Received byte is the first after selection |
| tx_req_o | output | 1 | One-cycle request for the next byte to send |
| stop_o | output | 1 | One-cycle strobe on STOP |

## Verification
A wrong phase or bit count shows up at the ports within one bus bit. The data line is released or pulled at the wrong clock fall, and this is visible in the cycle right after that fall. The reference model predicts the pull enable for every clock cycle, so a shifted acknowledge or a data bit in the wrong place is caught in that cycle. A lost selection decision shows up at the next acknowledge clock, or as a missing or extra byte strobe or request, which is compared once the transfer ends.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam int TAG_W  = 4;
  localparam int PAGE_W = 2;
  localparam int BYTE_W = TAG_W + 1 + PAGE_W + 1;
  localparam int CNT_W  = $clog2(BYTE_W + 2);

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SEL,
    PH_WR,
    PH_RD
  } phase_e;
endpackage

// File: rtl/twi_line_events.sv
module twi_line_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic rise_o,
  output logic fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign rise_o  = scl_i & ~scl_q;
  assign fall_o  = ~scl_i & scl_q;
  assign start_o = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/twi_byte_shifter.sv
module twi_byte_shifter
  import twi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              sda_i,
  input  logic              rx_en_i,
  input  logic              tx_shift_i,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] load_val_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              next_bit_o
);
  localparam logic [CNT_W-1:0] CNT_DATA = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_END  = CNT_W'(BYTE_W + 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              cnt_en;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              sh_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (clr_i) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (rise_i && (cnt_q <= CNT_DATA)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end else if (fall_i && (cnt_q == CNT_END)) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end
  end

  always_comb begin
    sh_en = 1'b0;
    sh_d  = sh_q;
    if (load_i) begin
      sh_en = 1'b1;
      sh_d  = load_val_i;
    end else if (rise_i && rx_en_i && (cnt_q < CNT_DATA)) begin
      sh_en = 1'b1;
      sh_d  = {sh_q[BYTE_W-2:0], sda_i};
    end else if (tx_shift_i) begin
      sh_en = 1'b1;
      sh_d  = {sh_q[BYTE_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      if (sh_en)  sh_q  <= sh_d;
    end
  end

  assign cnt_o      = cnt_q;
  assign rx_byte_o  = {sh_q[BYTE_W-2:0], sda_i};
  assign next_bit_o = sh_q[BYTE_W-2];
endmodule

// File: rtl/twi_sel_decode.sv
module twi_sel_decode
  import twi_pkg::*;
#(
  parameter logic [TAG_W-1:0] DEV_TAG = 4'b1010
) (
  input  logic              [BYTE_W-1:0] byte_i,
  input  logic                           strap_i,
  input  logic                           busy_i,
  output logic                           hit_o,
  output logic              [PAGE_W-1:0] page_o,
  output logic                           rnw_o
);
  localparam int TAG_LSB   = BYTE_W - TAG_W;
  localparam int STRAP_BIT = TAG_LSB - 1;

  assign hit_o  = (byte_i[BYTE_W-1:TAG_LSB] == DEV_TAG) &&
                  (byte_i[STRAP_BIT] == strap_i) && !busy_i;
  assign page_o = byte_i[STRAP_BIT-1:1];
  assign rnw_o  = byte_i[0];
endmodule

// File: rtl/twi_slave_engine.sv
module twi_slave_engine
  import twi_pkg::*;
#(
  parameter logic [TAG_W-1:0] DEV_TAG = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              strap_i,
  input  logic              wr_busy_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  output logic              sda_pull_o,
  output logic [PAGE_W-1:0] page_o,
  output logic              rnw_o,
  output logic              rx_valid_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              rx_word_o,
  output logic              tx_req_o,
  output logic              stop_o
);
  localparam logic [CNT_W-1:0] CNT_LASTBIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] CNT_ACK     = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_END     = CNT_W'(BYTE_W + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  logic rise_w, fall_w, start_w, stop_w;

  twi_line_events u_events (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .scl_i   (scl_i),
    .sda_i   (sda_i),
    .rise_o  (rise_w),
    .fall_o  (fall_w),
    .start_o (start_w),
    .stop_o  (stop_w)
  );

  phase_e             ph_q, ph_d;
  logic [CNT_W-1:0]   cnt_w;
  logic [BYTE_W-1:0]  shin_w;
  logic               next_bit_w;
  logic               rx_en_w, tx_shift_w, load_w;

  twi_byte_shifter u_shift (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .clr_i      (start_w | stop_w),
    .rise_i     (rise_w),
    .fall_i     (fall_w),
    .sda_i      (sda_i),
    .rx_en_i    (rx_en_w),
    .tx_shift_i (tx_shift_w),
    .load_i     (load_w),
    .load_val_i (tx_byte_i),
    .cnt_o      (cnt_w),
    .rx_byte_o  (shin_w),
    .next_bit_o (next_bit_w)
  );

  logic              hit_w;
  logic [PAGE_W-1:0] sel_page_w;
  logic              sel_rnw_w;

  twi_sel_decode #(.DEV_TAG(DEV_TAG)) u_sel (
    .byte_i  (shin_w),
    .strap_i (strap_i),
    .busy_i  (wr_busy_i),
    .hit_o   (hit_w),
    .page_o  (sel_page_w),
    .rnw_o   (sel_rnw_w)
  );

  // bus timing points inside one byte frame
  logic byte_done, ack_rise, ack_fall, end_fall, mid_fall;
  assign byte_done = rise_w && (cnt_w == CNT_LASTBIT);
  assign ack_rise  = rise_w && (cnt_w == CNT_ACK);
  assign ack_fall  = fall_w && (cnt_w == CNT_ACK);
  assign end_fall  = fall_w && (cnt_w == CNT_END);
  assign mid_fall  = fall_w && (cnt_w != '0) && (cnt_w < CNT_ACK);

  assign rx_en_w    = (ph_q == PH_SEL) || (ph_q == PH_WR);
  assign tx_shift_w = (ph_q == PH_RD) && mid_fall;
  assign load_w     = (ph_q == PH_RD) && end_fall;

  logic              pull_q, pull_d;
  logic              ackp_q, ackp_d;
  logic              first_q, first_d;
  logic [PAGE_W-1:0] page_q, page_d;
  logic              rnw_q, rnw_d;
  logic              rxv_q, rxv_d;
  logic [BYTE_W-1:0] rxb_q, rxb_d;
  logic              rxw_q, rxw_d;
  logic              txr_q, txr_d;
  logic              stp_q, stp_d;

  always_comb begin
    ph_d    = ph_q;
    pull_d  = pull_q;
    ackp_d  = ackp_q;
    first_d = first_q;
    page_d  = page_q;
    rnw_d   = rnw_q;
    rxb_d   = rxb_q;
    rxw_d   = rxw_q;
    rxv_d   = 1'b0;
    txr_d   = 1'b0;
    stp_d   = 1'b0;

    if (start_w) begin
      ph_d   = PH_SEL;
      pull_d = 1'b0;
      ackp_d = 1'b0;
    end else if (stop_w) begin
      ph_d   = PH_IDLE;
      pull_d = 1'b0;
      ackp_d = 1'b0;
      stp_d  = 1'b1;
    end else if (ph_q != PH_IDLE) begin
      case (ph_q)
        PH_SEL: begin
          if (byte_done) begin
            if (hit_w) begin
              page_d  = sel_page_w;
              rnw_d   = sel_rnw_w;
              ackp_d  = 1'b1;
              first_d = 1'b1;
              txr_d   = sel_rnw_w;
              ph_d    = sel_rnw_w ? PH_RD : PH_WR;
            end else begin
              ph_d = PH_IDLE;
            end
          end
        end
        PH_WR: begin
          if (byte_done) begin
            rxv_d   = 1'b1;
            rxb_d   = shin_w;
            rxw_d   = first_q;
            first_d = 1'b0;
            ackp_d  = 1'b1;
          end
        end
        PH_RD: begin
          if (ack_rise && !ackp_q) begin
            if (!sda_i) txr_d = 1'b1;
            else        ph_d  = PH_IDLE;
          end
          if (mid_fall) pull_d = ~next_bit_w;
        end
        default: ph_d = PH_IDLE;
      endcase

      if (ack_fall) pull_d = ackp_q;
      if (end_fall) begin
        ackp_d = 1'b0;
        pull_d = (ph_q == PH_RD) ? ~tx_byte_i[BYTE_W-1] : 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      ph_q    <= PH_IDLE;
      pull_q  <= 1'b0;
      ackp_q  <= 1'b0;
      first_q <= 1'b0;
      page_q  <= '0;
      rnw_q   <= 1'b0;
      rxv_q   <= 1'b0;
      rxb_q   <= '0;
      rxw_q   <= 1'b0;
      txr_q   <= 1'b0;
      stp_q   <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      pull_q  <= pull_d;
      ackp_q  <= ackp_d;
      first_q <= first_d;
      page_q  <= page_d;
      rnw_q   <= rnw_d;
      rxv_q   <= rxv_d;
      rxb_q   <= rxb_d;
      rxw_q   <= rxw_d;
      txr_q   <= txr_d;
      stp_q   <= stp_d;
    end
  end

  assign sda_pull_o = pull_q;
  assign page_o     = page_q;
  assign rnw_o      = rnw_q;
  assign rx_valid_o = rxv_q;
  assign rx_byte_o  = rxb_q;
  assign rx_word_o  = rxw_q;
  assign tx_req_o   = txr_q;
  assign stop_o     = stp_q;
endmodule

// File: rtl/twi_slave_engine_chk.sv
module twi_slave_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_pull_o,
  input logic rnw_o,
  input logic rx_valid_o,
  input logic tx_req_o,
  input logic stop_o
);
  AST_PULL_HELD_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $past(scl_i) |-> $stable(sda_pull_o)); // R10

  AST_RX_ON_SCL_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> $past(scl_i)); // R6

  AST_RX_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> !rnw_o); // R6

  AST_TXREQ_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req_o |-> (rnw_o && !rx_valid_o)); // R8

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o |-> !sda_pull_o); // R9
endmodule

bind twi_slave_engine twi_slave_engine_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scl_i      (scl_i),
  .sda_pull_o (sda_pull_o),
  .rnw_o      (rnw_o),
  .rx_valid_o (rx_valid_o),
  .tx_req_o   (tx_req_o),
  .stop_o     (stop_o)
);

// File: tb/twi_slave_engine_bench.sv
module twi_slave_engine_bench;
  localparam int H = 3;

  logic       clk;
  logic       rst_n;
  logic       scl;
  logic       m_sda;
  logic       strap;
  logic       busy;
  logic [7:0] tx_byte;
  logic       sda_pull;
  logic [1:0] page;
  logic       rnw;
  logic       rx_valid;
  logic [7:0] rx_byte;
  logic       rx_word;
  logic       tx_req;
  logic       stop_p;
  logic       sda_bus;

  assign sda_bus = m_sda & ~sda_pull;

  twi_slave_engine u_twi_slave_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl),
    .sda_i      (sda_bus),
    .strap_i    (strap),
    .wr_busy_i  (busy),
    .tx_byte_i  (tx_byte),
    .sda_pull_o (sda_pull),
    .page_o     (page),
    .rnw_o      (rnw),
    .rx_valid_o (rx_valid),
    .rx_byte_o  (rx_byte),
    .rx_word_o  (rx_word),
    .tx_req_o   (tx_req),
    .stop_o     (stop_p)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int         total;
  int         bad;
  int         n_req;
  int         n_stop;
  logic       exp_pull;
  logic       chk_on;
  logic [8:0] rx_log[$];
  logic [7:0] rd_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // reference model: predicted pull for every clock, plus event logs
  always begin
    @(posedge clk);
    #1;
    if (chk_on) check(sda_pull === exp_pull, "R7", "pull model", sda_pull, exp_pull);
    if (rx_valid) rx_log.push_back({rx_word, rx_byte});
    if (tx_req) begin
      n_req++;
      tx_byte = (rd_q.size() > 0) ? rd_q.pop_front() : 8'h00;
    end
    if (stop_p) n_stop++;
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start();
    m_sda = 1'b1; wt(H);
    scl = 1'b1;   wt(H);
    m_sda = 1'b0; wt(H);
    scl = 1'b0;   exp_pull = 1'b0; wt(H);
  endtask

  task automatic do_stop();
    m_sda = 1'b0; wt(H);
    scl = 1'b1;   wt(H);
    m_sda = 1'b1; exp_pull = 1'b0; wt(H);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit ack_exp,
                           input bit nxt_pull, input string req);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wt(H);
      scl = 1'b1;   wt(H);
      scl = 1'b0;   exp_pull = (i == 0) ? ack_exp : 1'b0; wt(H);
    end
    m_sda = 1'b1; wt(H);
    scl = 1'b1;   wt(H);
    check(sda_bus == !ack_exp, req, "ack on ninth clock", sda_bus, !ack_exp);
    scl = 1'b0;   exp_pull = nxt_pull; wt(H);
  endtask

  task automatic recv_byte(input logic [7:0] e, input bit mack,
                           input bit nxt_pull, input string req);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(H);
      scl = 1'b1; wt(H);
      check(sda_bus == e[i], req, "read bit", sda_bus, e[i]);
      scl = 1'b0; exp_pull = (i == 0) ? 1'b0 : !e[i-1];
    end
    wt(H);
    m_sda = !mack; wt(H);
    scl = 1'b1;    wt(H);
    scl = 1'b0;    exp_pull = nxt_pull; wt(H);
    m_sda = 1'b1;
  endtask

  task automatic expect_rx(input bit w, input logic [7:0] b, input string req);
    logic [8:0] ent;
    if (rx_log.size() == 0) begin
      check(1'b0, req, "missing received byte", 0, {w, b});
    end else begin
      ent = rx_log.pop_front();
      check(ent == {w, b}, req, "received byte", ent, {w, b});
    end
  endtask

  initial begin
    total = 0; bad = 0; n_req = 0; n_stop = 0;
    chk_on = 1'b0; exp_pull = 1'b0;
    rst_n = 1'b0; scl = 1'b1; m_sda = 1'b1; strap = 1'b1; busy = 1'b0;
    tx_byte = 8'h00;
    wt(5);
    // R9: reset state
    check(sda_pull == 1'b0 && rx_valid == 1'b0 && tx_req == 1'b0 && stop_p == 1'b0,
          "R9", "outputs in reset", {sda_pull, rx_valid, tx_req, stop_p}, 0);
    rst_n = 1'b1;
    wt(5);
    chk_on = 1'b1;

    // R2 R5 R6: write with page 01, word address then two data bytes
    do_start();
    send_byte(8'hAA, 1'b1, 1'b0, "R2");
    check(page == 2'b01 && rnw == 1'b0, "R5", "page/dir after write select", {page, rnw}, 3'b010);
    send_byte(8'h3C, 1'b1, 1'b0, "R6");
    send_byte(8'hA5, 1'b1, 1'b0, "R6");
    send_byte(8'h5A, 1'b1, 1'b0, "R6");
    do_stop();
    wt(2);
    expect_rx(1'b1, 8'h3C, "R6");
    expect_rx(1'b0, 8'hA5, "R6");
    expect_rx(1'b0, 8'h5A, "R6");
    check(n_stop == 1, "R9", "stop strobe count", n_stop, 1);

    // R3: wrong tag, later matching byte still ignored
    do_start();
    send_byte(8'hB8, 1'b0, 1'b0, "R3");
    send_byte(8'hA8, 1'b0, 1'b0, "R3");
    do_stop();
    wt(2);
    check(rx_log.size() == 0, "R3", "no strobe after mismatch", rx_log.size(), 0);
    check(page == 2'b01, "R5", "page held across mismatch", page, 2'b01);

    // R3 then R2: strap comparison
    do_start();
    send_byte(8'hA0, 1'b0, 1'b0, "R3");
    do_stop();
    strap = 1'b0;
    do_start();
    send_byte(8'hA0, 1'b1, 1'b0, "R2");
    do_stop();
    strap = 1'b1;

    // R4: busy withholds ack, then polling succeeds
    busy = 1'b1;
    do_start();
    send_byte(8'hA8, 1'b0, 1'b0, "R4");
    do_stop();
    busy = 1'b0;
    do_start();
    send_byte(8'hA8, 1'b1, 1'b0, "R4");
    do_stop();
    wt(2);
    check(rx_log.size() == 0, "R4", "no data byte during polling", rx_log.size(), 0);

    // R7 R8: sequential read of two bytes ending in NACK
    n_req = 0;
    rd_q.push_back(8'h69);
    rd_q.push_back(8'hC3);
    do_start();
    send_byte(8'hAD, 1'b1, 1'b1, "R8");
    check(page == 2'b10 && rnw == 1'b1, "R5", "page/dir after read select", {page, rnw}, 3'b101);
    recv_byte(8'h69, 1'b1, 1'b0, "R7");
    recv_byte(8'hC3, 1'b0, 1'b0, "R7");
    // clocks after NACK: bus must stay released
    for (int k = 0; k < 9; k++) begin
      wt(H); scl = 1'b1; wt(H);
      check(sda_bus == 1'b1, "R8", "released after NACK", sda_bus, 1);
      scl = 1'b0;
    end
    wt(H);
    check(n_req == 2, "R8", "request count", n_req, 2);
    do_stop();

    // R1: repeated START in the middle of a selection byte
    do_start();
    for (int i = 7; i >= 4; i--) begin
      m_sda = 1'(8'hA8 >> i); wt(H);
      scl = 1'b1; wt(H);
      scl = 1'b0; wt(H);
    end
    do_start();
    send_byte(8'hAA, 1'b1, 1'b0, "R1");
    send_byte(8'h77, 1'b1, 1'b0, "R1");
    do_stop();
    wt(2);
    expect_rx(1'b1, 8'h77, "R1");

    // R1: random read, repeated START without STOP
    n_req = 0;
    rd_q.push_back(8'h81);
    do_start();
    send_byte(8'hA8, 1'b1, 1'b0, "R1");
    send_byte(8'h10, 1'b1, 1'b0, "R1");
    do_start();
    send_byte(8'hA9, 1'b1, 1'b0, "R1");
    recv_byte(8'h81, 1'b0, 1'b0, "R7");
    do_stop();
    wt(2);
    expect_rx(1'b1, 8'h10, "R1");
    check(n_req == 1, "R8", "single request in random read", n_req, 1);
    check(page == 2'b00 && rnw == 1'b1, "R5", "page/dir after random read", {page, rnw}, 3'b001);

    chk_on = 1'b0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule